// File: doc/BRIEF.md
# Digital and Analog Palette Register File

This block holds the colour palette of a display controller and exposes it through four byte-wide ports that share one address. A single mode input decides how those ports are understood. In digital mode each port holds one packed byte carrying two 3-bit colours, one in each nibble. In 16-colour analog mode the first port holds an entry index. The other three ports write and read the green, red and blue 4-bit components of the entry that index selects.

A sticky redraw flag tells the downstream pixel logic that a visible colour has changed. The flag is raised only when a write alters a bit that reaches the screen, or when the mode changes. The consumer clears it with a one-cycle pulse. Reads are combinational from the current address and mode.

Top module: `pal_regfile`

## Requirements
- R1: After reset, redraw is 0 and the analog index is 0. The digital entries 0, 1, 2 and 3 hold 0x04, 0x15, 0x26 and 0x37.
- R2: In digital mode (analog_mode=0), a write or read at addr 0, 1, 2 or 3 reaches digital entry 3, 1, 2 or 0 respectively. rd_data returns the full stored byte.
- R3: A digital write raises redraw only if (old XOR new) AND 0x77 is nonzero. Bits 3 and 7 are stored but never flag a change.
- R4: In analog mode (analog_mode=1), addr 0 writes and reads the full 8-bit index. An index write never changes redraw.
- R5: In analog mode, addr 1, 2 and 3 write the green, red and blue component of entry (index AND 15). Only wr_data[3:0] is stored. Reads return the component in bits 3:0 with bits 7:4 at 0.
- R6: An analog component write raises redraw only when the stored 4-bit value differs from wr_data[3:0].
- R7: After reset, each analog entry e takes its default values from index bits e[2], e[1] and e[0], which select green, red and blue. For e = 0 to 7 a set bit gives 7 and a clear bit gives 0. Entry 8 is 4/4/4. For e = 9 to 15 a set bit gives 15 and a clear bit gives 0.
- R8: redraw stays 1 until a cycle with redraw_clr=1. When a new change arrives in the same cycle as the clear, the change wins and redraw stays 1.
- R9: A change of analog_mode raises redraw one cycle later.
- R10: Digital writes leave the analog table and index untouched. Analog writes leave the digital entries untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| analog_mode | input | 1 | 1 selects 16-colour analog mode, 0 selects digital mode |
| wr_en | input | 1 | Write strobe for addr and wr_data |
| addr | input | 2 | Port offset, used for both write and read |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for addr in the current mode |
| redraw_clr | input | 1 | One-cycle clear of the redraw flag |
| redraw | output | 1 | Sticky flag: a visible colour or the mode has changed |

## Verification
The assertions assume that analog_mode, wr_en, addr and wr_data settle before the clock edge. They also assume redraw_clr is a single-cycle pulse, so a rise of redraw can always be traced to a write or a mode change in the previous cycle. The stimulus changes every input only on the falling edge. Mode changes are applied with wr_en low, so the flag raised by a mode change can be told apart from the flag raised by a write. Clears are issued as one-cycle pulses, except in the case that deliberately overlaps a clear with a write that changes a colour.

// File: rtl/pal_regfile.sv
module pal_regfile (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       analog_mode,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       redraw_clr,
  output logic       redraw
);

  localparam int ENTRIES = 16;

  logic [7:0] dpal [4];
  logic [3:0] grn [ENTRIES];
  logic [3:0] red [ENTRIES];
  logic [3:0] blu [ENTRIES];
  logic [7:0] idx;
  logic       mode_q;

  function automatic logic [3:0] dflt(int e, int bitpos);
    logic on;
    on = ((e >> bitpos) & 1) != 0;
    if (e == 8)      return 4'd4;
    else if (e < 8)  return on ? 4'd7 : 4'd0;
    else             return on ? 4'd15 : 4'd0;
  endfunction

  logic [1:0] dsel;
  logic [3:0] ent;
  logic [3:0] cur_cmp;
  logic       wr_dig, wr_idx, wr_cmp, dig_chg, cmp_chg, set_rd;

  assign dsel   = (addr[0] == addr[1]) ? ~addr : addr;
  assign ent    = idx[3:0];
  assign wr_dig = wr_en && !analog_mode;
  assign wr_idx = wr_en && analog_mode && addr == 2'd0;
  assign wr_cmp = wr_en && analog_mode && addr != 2'd0;

  always_comb begin
    case (addr)
      2'd1:    cur_cmp = grn[ent];
      2'd2:    cur_cmp = red[ent];
      default: cur_cmp = blu[ent];
    endcase
  end

  assign dig_chg = |((dpal[dsel] ^ wr_data) & 8'h77);
  assign cmp_chg = cur_cmp != wr_data[3:0];
  assign set_rd  = (wr_dig && dig_chg) || (wr_cmp && cmp_chg) || (analog_mode != mode_q);

  assign rd_data = !analog_mode ? dpal[dsel] :
                   (addr == 2'd0) ? idx : {4'b0000, cur_cmp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 4; e++) dpal[e] <= 8'h04 + 8'(17 * e);
      for (int e = 0; e < ENTRIES; e++) begin
        grn[e] <= dflt(e, 2);
        red[e] <= dflt(e, 1);
        blu[e] <= dflt(e, 0);
      end
      idx    <= 8'h00;
      mode_q <= 1'b0;
      redraw <= 1'b0;
    end else begin
      mode_q <= analog_mode;
      redraw <= set_rd || (redraw && !redraw_clr);
      if (wr_dig) dpal[dsel] <= wr_data;
      if (wr_idx) idx <= wr_data;
      if (wr_cmp) begin
        case (addr)
          2'd1:    grn[ent] <= wr_data[3:0];
          2'd2:    red[ent] <= wr_data[3:0];
          default: blu[ent] <= wr_data[3:0];
        endcase
      end
    end
  end

  logic [31:0] dpal_flat;
  logic [191:0] ana_flat;
  always_comb begin
    dpal_flat = {dpal[3], dpal[2], dpal[1], dpal[0]};
    for (int e = 0; e < ENTRIES; e++)
      ana_flat[e*12 +: 12] = {grn[e], red[e], blu[e]};
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redraw && !redraw_clr |=> redraw);

  p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redraw) |-> ($past(wr_en) || mode_q != $past(mode_q)));

  p_index_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && analog_mode && mode_q && addr == 2'd0 && !redraw_clr |=> redraw == $past(redraw));

  p_dig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !analog_mode) |=> $stable(dpal_flat));

  p_ana_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && analog_mode) |=> $stable(ana_flat) && $stable(idx));

endmodule

// File: tb/sim_pal_regfile.sv
module sim_pal_regfile;
  logic clk = 0, rst_n = 0, analog_mode = 0, wr_en = 0, redraw_clr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic redraw;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pal_regfile u0 (.clk(clk), .rst_n(rst_n), .analog_mode(analog_mode), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .redraw_clr(redraw_clr), .redraw(redraw));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rd_data;
  endtask

  task automatic clr();
    @(negedge clk); redraw_clr = 1;
    @(negedge clk); redraw_clr = 0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); analog_mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 redraw", {7'd0, redraw}, 8'h00);
    rd(0, v); check("R1/R2 addr0", v, 8'h37);
    rd(1, v); check("R1/R2 addr1", v, 8'h15);
    rd(2, v); check("R1/R2 addr2", v, 8'h26);
    rd(3, v); check("R1/R2 addr3", v, 8'h04);
  endtask

  task automatic t_mode_flag();
    set_mode(1); check("R9 mode rise", {7'd0, redraw}, 8'h01);
    clr(); check("R8 cleared", {7'd0, redraw}, 8'h00);
  endtask

  task automatic t_defaults();
    logic [7:0] v;
    rd(0, v); check("R1 index", v, 8'h00);
    rd(1, v); check("R7 e0 g", v, 8'h00);
    wr(0, 8'h08); check("R4 index no flag", {7'd0, redraw}, 8'h00);
    rd(1, v); check("R7 e8 g", v, 8'h04);
    rd(2, v); check("R7 e8 r", v, 8'h04);
    rd(3, v); check("R7 e8 b", v, 8'h04);
    wr(0, 8'h1D);
    rd(0, v); check("R4 index read", v, 8'h1D);
    rd(1, v); check("R5/R7 e13 g", v, 8'h0F);
    rd(2, v); check("R7 e13 r", v, 8'h00);
    rd(3, v); check("R7 e13 b", v, 8'h0F);
    wr(0, 8'h05);
    rd(1, v); check("R7 e5 g", v, 8'h07);
    rd(2, v); check("R7 e5 r", v, 8'h00);
    rd(3, v); check("R7 e5 b", v, 8'h07);
  endtask

  task automatic t_ana_write();
    logic [7:0] v;
    wr(1, 8'hF7); check("R6 high nibble no flag", {7'd0, redraw}, 8'h00);
    rd(1, v); check("R5 g keep", v, 8'h07);
    wr(1, 8'h03); check("R6 change flags", {7'd0, redraw}, 8'h01);
    rd(1, v); check("R5 g new", v, 8'h03);
    clr();
    wr(2, 8'hAC);
    rd(2, v); check("R5 r low nibble", v, 8'h0C);
    clr();
  endtask

  task automatic t_digital();
    logic [7:0] v;
    set_mode(0); check("R9 mode fall", {7'd0, redraw}, 8'h01);
    clr();
    wr(3, 8'h0C); check("R3 bit3 no flag", {7'd0, redraw}, 8'h00);
    rd(3, v); check("R2/R3 e0 stored", v, 8'h0C);
    wr(0, 8'h30); check("R3 change flags", {7'd0, redraw}, 8'h01);
    rd(0, v); check("R2 e3", v, 8'h30);
    rd(1, v); check("R10 e1 kept", v, 8'h15);
    rd(2, v); check("R10 e2 kept", v, 8'h26);
    clr();
    @(negedge clk); redraw_clr = 1; wr_en = 1; addr = 1; wr_data = 8'h51;
    @(negedge clk); redraw_clr = 0; wr_en = 0;
    check("R8 set wins", {7'd0, redraw}, 8'h01);
    clr(); check("R8 clear", {7'd0, redraw}, 8'h00);
    @(negedge clk); redraw_clr = 1; wr_en = 1; addr = 1; wr_data = 8'hD9;
    @(negedge clk); redraw_clr = 0; wr_en = 0;
    check("R3 bit7/3 no flag", {7'd0, redraw}, 8'h00);
  endtask

  task automatic t_isolation();
    logic [7:0] v;
    set_mode(1); clr();
    rd(0, v); check("R10 index kept", v, 8'h05);
    rd(1, v); check("R10 g kept", v, 8'h03);
    rd(2, v); check("R10 r kept", v, 8'h0C);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode_flag();
    t_defaults();
    t_ana_write();
    t_digital();
    t_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule